// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

The block tracks the shaft position of an incremental encoder from its two phase outputs. Both phase inputs arrive with no timing relation to the clock, so each one is first brought into the clock domain. The block then compares the phase pair seen this cycle with the pair seen one cycle earlier. A four-input decode of that comparison gives a count-enable and a count-direction bit. Both bits are registered, and they drive an up/down position counter. A parallel output shows the counter value. A synchronous clear returns the counter to zero.

The phase pair `{enc_a, enc_b}` is treated as a four-state machine. The states are PH_00, PH_01, PH_11 and PH_10. The decoder classifies each cycle's transition as one of four moves:

- **MV_FWD**: one step along PH_00→PH_01→PH_11→PH_10→PH_00. The count goes up by one.
- **MV_REV**: one step along the reverse ring. The count goes down by one.
- **MV_HOLD**: the pair did not change. There is no count.
- **MV_SKIP**: both phases changed in the same cycle. The step is ambiguous, so there is no count.

The block does no filtering. It accepts one legal step on every clock edge, which gives four counts per encoder cycle.

Top module: `qenc_position_counter`

## Requirements
- R1: When `clr` is high at a rising edge, `position` is zero after that edge, and any pending count-enable is discarded.
- R2: Each step of the phase pair `{enc_a,enc_b}` along 00→01→11→10→00 raises `position` by exactly one.
- R3: Each step along the reverse ring 00→10→11→01→00 lowers `position` by exactly one.
- R4: While the phase pair does not change, `position` holds its value.
- R5: A cycle in which both `enc_a` and `enc_b` change together (e.g. 00→11) leaves `position` unchanged.
- R6: The counter wraps modulo 2^POS_W: one reverse step from zero gives all ones, and one forward step from all ones gives zero.
- R7: A phase change applied before rising edge n shows on `position` after rising edge n+3 and not earlier. The four registers on this path are the synchronizer, the current-phase register, the registered decode and the counter.
- R8: Legal steps applied on consecutive clock cycles are each counted; none is lost.
- R9: Outside a clear, `position` changes by at most one count per clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| clr | input | 1 | Synchronous active-high clear of counter and decode registers |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| position | output | POS_W (32) | Current signed-wrap position count |

## Verification
On every cycle, the assertions check four things. A hold or a double-phase change never produces a count-enable (R4, R5). The counter is stable whenever enable is low. A clear always lands on zero (R1). The position never moves by more than one per cycle (R9). Some behaviour can only be shown by the bench scenarios, which compare `position` against an independent phase-ring model. These are the sign of each step direction (R2, R3), the wrap at both ends (R6), the exact four-edge latency (R7), and the counting of back-to-back steps with none dropped (R8).

// File: rtl/qenc_pkg.sv
package qenc_pkg;

    // Phase pair {A,B} as a state
    typedef enum logic [1:0] {
        PH_00 = 2'b00,
        PH_01 = 2'b01,
        PH_11 = 2'b11,
        PH_10 = 2'b10
    } phase_e;

    // Classified move between two consecutive phase samples
    typedef enum logic [1:0] {
        MV_HOLD = 2'd0,
        MV_FWD  = 2'd1,
        MV_REV  = 2'd2,
        MV_SKIP = 2'd3
    } move_e;

    // Successor of a phase on the forward ring
    function automatic phase_e fwd_next(input phase_e p);
        phase_e n;
        unique case (p)
            PH_00: n = PH_01;
            PH_01: n = PH_11;
            PH_11: n = PH_10;
            PH_10: n = PH_00;
            default: n = PH_00;
        endcase
        return n;
    endfunction

    // Successor of a phase on the reverse ring
    function automatic phase_e rev_next(input phase_e p);
        phase_e n;
        unique case (p)
            PH_00: n = PH_10;
            PH_10: n = PH_11;
            PH_11: n = PH_01;
            PH_01: n = PH_00;
            default: n = PH_00;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/qenc_phase_sync.sv
module qenc_phase_sync #(
    parameter int CH          = 2,
    parameter int SYNC_STAGES = 1
) (
    input  logic          clk,
    input  logic          clr,
    input  logic [CH-1:0] raw_in,
    output logic [CH-1:0] cur_out,
    output logic [CH-1:0] prev_out
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [CH-1:0] meta_q [SYNC_STAGES];
    logic [CH-1:0] cur_q;
    logic [CH-1:0] prev_q;

    // Synchronizer stages: plain flop-to-flop, nothing in between
    always_ff @(posedge clk) begin
        meta_q[0] <= raw_in;
    end

    generate
        for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_extra
            always_ff @(posedge clk) begin
                meta_q[s] <= meta_q[s-1];
            end
        end
    endgenerate

    // Current and previous-cycle phase registers
    always_ff @(posedge clk) begin
        cur_q  <= meta_q[LAST];
        prev_q <= cur_q;
    end

    assign cur_out  = cur_q;
    assign prev_out = prev_q;

    // Previous sample is exactly the current sample one cycle late (R8)
    AST_PREV_TRACKS_CUR: assert property (@(posedge clk) disable iff (clr)
        prev_out == $past(cur_out)); // R8

endmodule

// File: rtl/qenc_step_decode.sv
module qenc_step_decode
    import qenc_pkg::*;
(
    input  logic   clk,
    input  logic   clr,
    input  phase_e prev_ph,
    input  phase_e cur_ph,
    output logic   step_en,
    output logic   step_dir
);
    move_e mv;
    logic  en_q;
    logic  dir_q;

    // Move classification over the full four-input table
    always_comb begin
        unique case (prev_ph)
            PH_00, PH_01, PH_11, PH_10: begin
                if (cur_ph == prev_ph)                mv = MV_HOLD;
                else if (cur_ph == fwd_next(prev_ph)) mv = MV_FWD;
                else if (cur_ph == rev_next(prev_ph)) mv = MV_REV;
                else                                  mv = MV_SKIP;
            end
            default: mv = MV_HOLD;
        endcase
    end

    // Registered outputs of the table
    always_ff @(posedge clk) begin
        if (clr) begin
            en_q  <= 1'b0;
            dir_q <= 1'b0;
        end else begin
            en_q  <= (mv == MV_FWD) || (mv == MV_REV);
            dir_q <= (mv == MV_REV);
        end
    end

    assign step_en  = en_q;
    assign step_dir = dir_q;

    AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (clr)
        (prev_ph == cur_ph) |=> !step_en); // R4
    AST_SKIP_NO_STEP: assert property (@(posedge clk) disable iff (clr)
        ((prev_ph ^ cur_ph) == 2'b11) |=> !step_en); // R5
    AST_CLEAR_DROPS_EN: assert property (@(posedge clk)
        clr |=> !step_en); // R1

endmodule

// File: rtl/qenc_pos_counter.sv
module qenc_pos_counter #(
    parameter int POS_W = 32
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             step_en,
    input  logic             step_dir,
    output logic [POS_W-1:0] pos
);
    localparam logic [POS_W-1:0] ONE = POS_W'(1);

    logic [POS_W-1:0] pos_q;

    always_ff @(posedge clk) begin
        if (clr)
            pos_q <= '0;
        else if (step_en)
            pos_q <= step_dir ? pos_q - ONE : pos_q + ONE;
    end

    assign pos = pos_q;

    AST_CLEAR_ZERO: assert property (@(posedge clk)
        clr |=> pos == '0); // R1
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (clr)
        !step_en |=> $stable(pos)); // R4

endmodule

// File: rtl/qenc_position_counter.sv
module qenc_position_counter
    import qenc_pkg::*;
#(
    parameter int POS_W       = 32,
    parameter int SYNC_STAGES = 1
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             enc_a,
    input  logic             enc_b,
    output logic [POS_W-1:0] position
);
    localparam logic [POS_W-1:0] ONE = POS_W'(1);

    logic [1:0] cur_bits;
    logic [1:0] prev_bits;
    logic       step_en;
    logic       step_dir;

    qenc_phase_sync #(
        .CH          (2),
        .SYNC_STAGES (SYNC_STAGES)
    ) sync_i (
        .clk      (clk),
        .clr      (clr),
        .raw_in   ({enc_a, enc_b}),
        .cur_out  (cur_bits),
        .prev_out (prev_bits)
    );

    qenc_step_decode decode_i (
        .clk      (clk),
        .clr      (clr),
        .prev_ph  (phase_e'(prev_bits)),
        .cur_ph   (phase_e'(cur_bits)),
        .step_en  (step_en),
        .step_dir (step_dir)
    );

    qenc_pos_counter #(
        .POS_W (POS_W)
    ) counter_i (
        .clk      (clk),
        .clr      (clr),
        .step_en  (step_en),
        .step_dir (step_dir),
        .pos      (position)
    );

    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (clr)
        1'b1 |=> (position == $past(position)) ||
                 (position == $past(position) + ONE) ||
                 (position == $past(position) - ONE)); // R9

endmodule

// File: tb/qenc_position_counter_tb_top.sv
module qenc_position_counter_tb_top;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         clr = 1'b1;
    logic         enc_a = 1'b0;
    logic         enc_b = 1'b0;
    logic [W-1:0] position;

    int unsigned cyc = 0;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    typedef struct {
        int unsigned  stamp;
        logic [W-1:0] val;
        string        req;
    } item_t;

    item_t        sb_q[$];
    logic [1:0]   ph_model = 2'b00;
    logic [W-1:0] pos_model = '0;

    always #4 clk = ~clk;   // 125 MHz
    always @(posedge clk) cyc <= cyc + 1;

    qenc_position_counter #(.POS_W(W)) dut_i (
        .clk      (clk),
        .clr      (clr),
        .enc_a    (enc_a),
        .enc_b    (enc_b),
        .position (position)
    );

    function automatic int ring_idx(input logic [1:0] p);
        case (p)
            2'b00: return 0;
            2'b01: return 1;
            2'b11: return 2;
            default: return 3;
        endcase
    endfunction

    function automatic int step_delta(input logic [1:0] p, input logic [1:0] c);
        int d;
        d = (ring_idx(c) - ring_idx(p) + 4) % 4;
        if (d == 1) return 1;
        if (d == 3) return -1;
        return 0;
    endfunction

    task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: position=%h expected=%h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Monitor: pops expected items when their cycle arrives
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].stamp <= cyc) begin
            check(position, sb_q[0].val, sb_q[0].req);
            void'(sb_q.pop_front());
        end
    end

    // Driver: apply one phase pair, predict old value one edge before, new value at the fourth edge
    task automatic drive(input logic [1:0] nxt, input string req, input bit b2b);
        item_t it;
        it.stamp = cyc + 3; it.val = pos_model; it.req = "R7";
        sb_q.push_back(it);
        pos_model = pos_model + W'(step_delta(ph_model, nxt));
        ph_model  = nxt;
        {enc_a, enc_b} = nxt;
        it.stamp = cyc + 4; it.val = pos_model; it.req = req;
        sb_q.push_back(it);
        if (b2b) @(negedge clk);
        else repeat (6) @(negedge clk);
    endtask

    task automatic drain();
        while (sb_q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic do_clear();
        drain();
        clr = 1'b1;
        @(negedge clk);
        check(position, '0, "R1");
        clr = 1'b0;
        pos_model = '0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        clr = 1'b1;
        repeat (5) @(negedge clk);
        check(position, '0, "R1");
        clr = 1'b0;
        repeat (2) @(negedge clk);

        // R2: forward ring, two full cycles
        for (int k = 0; k < 2; k++) begin
            drive(2'b01, "R2", 0);
            drive(2'b11, "R2", 0);
            drive(2'b10, "R2", 0);
            drive(2'b00, "R2", 0);
        end
        // R3: reverse steps
        drive(2'b10, "R3", 0);
        drive(2'b11, "R3", 0);
        drive(2'b01, "R3", 0);
        // R4: hold, verify unchanged after a long idle
        drain();
        repeat (10) @(negedge clk);
        check(position, pos_model, "R4");
        // R5: both phases change at once (01 -> 10), then 10 -> 11
        drive(2'b10, "R5", 0);
        drive(2'b11, "R5", 0);
        drive(2'b00, "R5", 0);
        // R8: back-to-back forward then reverse steps, one per cycle
        drive(2'b01, "R8", 1);
        for (int k = 0; k < 3; k++) begin
            drive(2'b11, "R8", 1);
            drive(2'b10, "R8", 1);
            drive(2'b00, "R8", 1);
            drive(2'b01, "R8", 1);
        end
        drive(2'b00, "R8", 1);
        drive(2'b10, "R8", 1);
        drain();
        check(position, pos_model, "R8");

        // R6: wrap below zero and back
        do_clear();
        drive(2'b00, "R6", 0);   // align to 00 if not there
        drain();
        do_clear();
        drive(2'b10, "R6", 0);
        drain();
        check(position, {W{1'b1}}, "R6");
        drive(2'b00, "R6", 0);
        drain();
        check(position, '0, "R6");

        // R1: clear in the middle of counting
        drive(2'b01, "R2", 0);
        drive(2'b11, "R2", 0);
        do_clear();
        check(position, '0, "R1");

        drain();
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule